// File: doc/BRIEF.md
# I2C Target General-Call Command Front End

This block is the bus-facing front end of a small I2C target. It oversamples SCL and SDA with the system clock through a synchroniser and finds START and STOP conditions. It shifts in bytes MSB first and acknowledges the bytes it accepts by pulling SDA low. It acts on two broadcast commands sent to the general-call address. One makes the device reset as if power had just come up and ask for its stored settings to be reloaded. The other puts the output stage back into normal operation by clearing its power-down bits. The stored power-down setting is not touched.

The block also detects the high-speed master code. It does not acknowledge that byte, but it raises a flag that the rest of the device uses to switch its bus timing. The flag holds through repeated STARTs and clears at the next STOP. Read transfers, the device's own address, the analog stage and the nonvolatile store belong to neighbouring blocks. They see this block only through its pulses and its flag.

Top module: `i2c_gencall_target`

## Requirements
- R1: A first byte of 0x00 after START (general call) is acknowledged: SDA is pulled low for the whole ninth SCL pulse.
- R2: A general call followed by 0x06 is acknowledged and gives exactly one single-cycle `reloadPulse` at the ninth SCL rising edge of that byte, and no `pdClearPulse`.
- R3: A general call followed by 0x09 is acknowledged and gives exactly one single-cycle `pdClearPulse`, and no `reloadPulse`.
- R4: A general call followed by 0x00 is not acknowledged (SDA is left released in the ninth pulse) and gives no pulse.
- R5: A general call followed by any other value is acknowledged and gives no pulse.
- R6: A first byte whose top five bits are 00001 (high-speed master code) is not acknowledged and sets `hsMode` high.
- R7: `hsMode` stays high through repeated STARTs and clears on the next STOP.
- R8: A first byte that is neither 0x00 nor a high-speed code is not acknowledged, and the bytes that follow it in the same transfer (including 0x06) are neither acknowledged nor acted on.
- R9: A START in the middle of a byte throws away the bits received so far, and the next byte is taken as a new first byte.
- R10: The reset command (0x06) also clears `hsMode`, in the same way a power-up would.
- R11: The SDA pull-down is released after the SCL falling edge that ends the ninth pulse, and it is never active after reset or outside an acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| sdaPullLow | output | 1 | Drives the SDA open-drain pull-down for ACK |
| reloadPulse | output | 1 | One-cycle request to reset and reload stored settings |
| pdClearPulse | output | 1 | One-cycle request to clear the working power-down bits |
| hsMode | output | 1 | High-speed master code seen, held until STOP |

## Verification
The hardest case to reach from the ports is a START that arrives in the middle of a byte. The bit counter must be partway through a frame and then drop the partial byte. The bench creates this by clocking out four address bits by hand and then raising SCL with SDA high and pulling SDA low. The expected reload after that abort shows that the next byte was taken as a fresh address. Keeping high-speed mode alive across a repeated START also needs a multi-phase transfer: master code, repeated START, general call, and then STOP. The flag is sampled between each step.

// File: rtl/i2c_gc_pkg.sv
package i2c_gc_pkg;

  // Events found on the bus by the datapath, consumed by the control
  typedef struct packed {
    logic startDet;
    logic stopDet;
    logic byteDone;   // last data bit sampled this cycle
    logic dataFall;   // SCL falling after the last data bit
    logic ackRise;    // SCL rising of the acknowledge pulse
    logic frameEnd;   // SCL falling that ends the acknowledge pulse
  } busEvents_t;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic captureEn;
    logic frameRestart;
  } ctlStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_GCCMD,
    ST_SKIP
  } gcState_e;

  typedef enum logic [1:0] {
    CMD_NONE,
    CMD_RESET,
    CMD_WAKE
  } gcCmd_e;

  localparam logic [4:0] HS_PREFIX = 5'b00001;

endpackage

// File: rtl/i2c_gc_datapath.sv
module i2c_gc_datapath
  import i2c_gc_pkg::*;
#(
  parameter int BYTE_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sclIn,
  input  logic                 sdaIn,
  input  ctlStrobes_t          ctl,
  output busEvents_t           ev,
  output logic [BYTE_BITS-1:0] rxNext
);

  localparam int CNT_W   = $clog2(BYTE_BITS + 2);
  localparam int ACK_CNT = BYTE_BITS;
  localparam int END_CNT = BYTE_BITS + 1;

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclS, sdaS, sclPrev, sdaPrev;
  logic sclRise, sclFall;
  logic [BYTE_BITS-1:0] shiftReg;
  logic [CNT_W-1:0] bitCnt;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : gSync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclSync[g] <= 1'b1;
          sdaSync[g] <= 1'b1;
        end else if (g == 0) begin
          sclSync[g] <= sclIn;
          sdaSync[g] <= sdaIn;
        end else begin
          sclSync[g] <= sclSync[(g == 0) ? 0 : g-1];
          sdaSync[g] <= sdaSync[(g == 0) ? 0 : g-1];
        end
      end
    end
  endgenerate

  assign sclS = sclSync[SYNC_STAGES-1];
  assign sdaS = sdaSync[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclRise = sclS & ~sclPrev;
  assign sclFall = ~sclS & sclPrev;

  always_comb begin
    ev.startDet = sclS & sclPrev & sdaPrev & ~sdaS;
    ev.stopDet  = sclS & sclPrev & ~sdaPrev & sdaS;
    ev.byteDone = sclRise & ctl.captureEn & (bitCnt == CNT_W'(BYTE_BITS - 1));
    ev.dataFall = sclFall & (bitCnt == CNT_W'(ACK_CNT));
    ev.ackRise  = sclRise & ctl.captureEn & (bitCnt == CNT_W'(ACK_CNT));
    ev.frameEnd = sclFall & (bitCnt == CNT_W'(END_CNT));
  end

  assign rxNext = {shiftReg[BYTE_BITS-2:0], sdaS};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
    end else if (ev.startDet || ctl.frameRestart) begin
      bitCnt <= '0;
    end else if (sclRise && ctl.captureEn) begin
      if (bitCnt < CNT_W'(ACK_CNT)) begin
        shiftReg <= rxNext;
        bitCnt   <= bitCnt + 1'b1;
      end else if (bitCnt == CNT_W'(ACK_CNT)) begin
        bitCnt <= CNT_W'(END_CNT);
      end
    end
  end

  // R9: a START always rewinds the frame
  p_start_rewinds_r9: assert property (@(posedge clk) disable iff (!rstN)
    ev.startDet |=> (bitCnt == '0));

  // R11: the counter never runs past the acknowledge slot
  p_cnt_bounded_r11: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(END_CNT));

endmodule

// File: rtl/i2c_gc_control.sv
module i2c_gc_control
  import i2c_gc_pkg::*;
#(
  parameter int             BYTE_BITS = 8,
  parameter logic [7:0]     GC_ADDR   = 8'h00,
  parameter logic [7:0]     RESET_CMD = 8'h06,
  parameter logic [7:0]     WAKE_CMD  = 8'h09
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  busEvents_t           ev,
  input  logic [BYTE_BITS-1:0] rxNext,
  output ctlStrobes_t          ctl,
  output logic                 sdaPullLow,
  output logic                 reloadPulse,
  output logic                 pdClearPulse,
  output logic                 hsMode
);

  gcState_e state;
  gcCmd_e   cmdPending;
  logic     ackPending;

  assign ctl.captureEn    = (state != ST_IDLE);
  assign ctl.frameRestart = ev.frameEnd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      cmdPending   <= CMD_NONE;
      ackPending   <= 1'b0;
      sdaPullLow   <= 1'b0;
      reloadPulse  <= 1'b0;
      pdClearPulse <= 1'b0;
      hsMode       <= 1'b0;
    end else begin
      reloadPulse  <= 1'b0;
      pdClearPulse <= 1'b0;
      if (ev.stopDet) begin
        state      <= ST_IDLE;
        cmdPending <= CMD_NONE;
        ackPending <= 1'b0;
        sdaPullLow <= 1'b0;
        hsMode     <= 1'b0;
      end else if (ev.startDet) begin
        state      <= ST_ADDR;
        cmdPending <= CMD_NONE;
        ackPending <= 1'b0;
        sdaPullLow <= 1'b0;
      end else begin
        if (ev.byteDone) begin
          case (state)
            ST_ADDR: begin
              if (rxNext == GC_ADDR) begin
                ackPending <= 1'b1;
                state      <= ST_GCCMD;
              end else begin
                if (rxNext[BYTE_BITS-1 -: 5] == HS_PREFIX) hsMode <= 1'b1;
                state <= ST_SKIP;
              end
            end
            ST_GCCMD: begin
              state <= ST_SKIP;
              if (rxNext == RESET_CMD) begin
                ackPending <= 1'b1;
                cmdPending <= CMD_RESET;
              end else if (rxNext == WAKE_CMD) begin
                ackPending <= 1'b1;
                cmdPending <= CMD_WAKE;
              end else if (rxNext != '0) begin
                ackPending <= 1'b1;
              end
            end
            default: ;
          endcase
        end
        if (ev.dataFall && ackPending) sdaPullLow <= 1'b1;
        if (ev.ackRise) begin
          if (cmdPending == CMD_RESET) begin
            reloadPulse <= 1'b1;
            hsMode      <= 1'b0;
          end
          if (cmdPending == CMD_WAKE) pdClearPulse <= 1'b1;
          cmdPending <= CMD_NONE;
        end
        if (ev.frameEnd) begin
          sdaPullLow <= 1'b0;
          ackPending <= 1'b0;
        end
      end
    end
  end

  // R2: the reload request lasts a single cycle
  p_reload_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    reloadPulse |=> !reloadPulse);

  // R3: the power-down clear lasts a single cycle
  p_clear_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    pdClearPulse |=> !pdClearPulse);

  // R6: entering high-speed mode never comes with an acknowledge
  p_hs_no_ack_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hsMode) |-> !sdaPullLow);

  // R7: a STOP always leaves high-speed mode
  p_hs_stop_r7: assert property (@(posedge clk) disable iff (!rstN)
    ev.stopDet |=> !hsMode);

  // R11: the pull-down is gone after the acknowledge pulse ends
  p_ack_release_r11: assert property (@(posedge clk) disable iff (!rstN)
    ev.frameEnd |=> !sdaPullLow);

endmodule

// File: rtl/i2c_gencall_target.sv
module i2c_gencall_target
  import i2c_gc_pkg::*;
#(
  parameter int         BYTE_BITS   = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] GC_ADDR     = 8'h00,
  parameter logic [7:0] RESET_CMD   = 8'h06,
  parameter logic [7:0] WAKE_CMD    = 8'h09
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaPullLow,
  output logic reloadPulse,
  output logic pdClearPulse,
  output logic hsMode
);

  busEvents_t           ev;
  ctlStrobes_t          ctl;
  logic [BYTE_BITS-1:0] rxNext;

  i2c_gc_datapath #(
    .BYTE_BITS  (BYTE_BITS),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_datapath (
    .clk   (clk),
    .rstN  (rstN),
    .sclIn (sclIn),
    .sdaIn (sdaIn),
    .ctl   (ctl),
    .ev    (ev),
    .rxNext(rxNext)
  );

  i2c_gc_control #(
    .BYTE_BITS(BYTE_BITS),
    .GC_ADDR  (GC_ADDR),
    .RESET_CMD(RESET_CMD),
    .WAKE_CMD (WAKE_CMD)
  ) u_control (
    .clk         (clk),
    .rstN        (rstN),
    .ev          (ev),
    .rxNext      (rxNext),
    .ctl         (ctl),
    .sdaPullLow  (sdaPullLow),
    .reloadPulse (reloadPulse),
    .pdClearPulse(pdClearPulse),
    .hsMode      (hsMode)
  );

  // R2/R3: the two command pulses never coincide
  p_pulses_apart_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(reloadPulse && pdClearPulse));

endmodule

// File: tb/i2c_gencall_target_bench.sv
module i2c_gencall_target_bench;

  localparam int Q = 20;  // quarter SCL period in system clocks

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclDrv = 1'b1;
  logic sdaDrv = 1'b1;
  logic sdaPullLow, reloadPulse, pdClearPulse, hsMode;
  logic sdaBus;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int expQ[$];  // 1 = reload, 2 = power-down clear

  always #2 clk = ~clk;  // 250 MHz

  assign sdaBus = sdaDrv & ~sdaPullLow;

  i2c_gencall_target u_i2c_gencall_target (
    .clk         (clk),
    .rstN        (rstN),
    .sclIn       (sclDrv),
    .sdaIn       (sdaBus),
    .sdaPullLow  (sdaPullLow),
    .reloadPulse (reloadPulse),
    .pdClearPulse(pdClearPulse),
    .hsMode      (hsMode)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitQ(input int n);
    repeat (n * Q) @(posedge clk);
    #1;
  endtask

  task automatic sendStart();
    sdaDrv = 1'b1; waitQ(1);
    sclDrv = 1'b1; waitQ(1);
    sdaDrv = 1'b0; waitQ(1);
    sclDrv = 1'b0; waitQ(1);
  endtask

  task automatic sendStop();
    sdaDrv = 1'b0; waitQ(1);
    sclDrv = 1'b1; waitQ(1);
    sdaDrv = 1'b1; waitQ(2);
  endtask

  task automatic sendBit(input logic b);
    sdaDrv = b;    waitQ(1);
    sclDrv = 1'b1; waitQ(2);
    sclDrv = 1'b0; waitQ(1);
  endtask

  // sends a byte, returns whether the target acknowledged it;
  // also checks the pull-down is released after the ninth pulse (R11)
  task automatic sendByte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    sdaDrv = 1'b1; waitQ(1);
    sclDrv = 1'b1; waitQ(1);
    acked = (sdaBus == 1'b0);
    waitQ(1);
    sclDrv = 1'b0; waitQ(1);
    check(sdaPullLow == 1'b0, "R11 release after ninth pulse", int'(sdaPullLow), 0);
  endtask

  // scoreboard monitor: every pulse must match the next expected item
  always @(negedge clk) begin
    if (rstN && (reloadPulse || pdClearPulse)) begin
      int got;
      got = reloadPulse ? 1 : 2;
      if (expQ.size() == 0) begin
        check(1'b0, "R2/R3/R4/R5/R8 unexpected pulse", got, 0);
      end else begin
        int want;
        want = expQ.pop_front();
        check(got == want, "R2/R3 pulse kind", got, want);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog expired", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    bit a1, a2;
    repeat (5) @(posedge clk);
    #1;
    check(sdaPullLow == 1'b0, "R11 reset pull-down", int'(sdaPullLow), 0);
    check(hsMode == 1'b0, "R7 reset hsMode", int'(hsMode), 0);
    check(reloadPulse == 1'b0 && pdClearPulse == 1'b0, "R2 reset pulses",
          int'(reloadPulse) + int'(pdClearPulse), 0);
    rstN = 1'b1;
    waitQ(2);

    // R1, R2: general call reset
    expQ.push_back(1);
    sendStart(); sendByte(8'h00, a1); sendByte(8'h06, a2); sendStop();
    check(a1, "R1 general call acked", int'(a1), 1);
    check(a2, "R2 reset command acked", int'(a2), 1);
    check(expQ.size() == 0, "R2 reload seen", expQ.size(), 0);

    // R3: wake-up
    expQ.push_back(2);
    sendStart(); sendByte(8'h00, a1); sendByte(8'h09, a2); sendStop();
    check(a2, "R3 wake command acked", int'(a2), 1);
    check(expQ.size() == 0, "R3 clear seen", expQ.size(), 0);

    // R4: illegal 0x00 second byte
    sendStart(); sendByte(8'h00, a1); sendByte(8'h00, a2); sendStop();
    check(!a2, "R4 zero command not acked", int'(a2), 0);

    // R5: other values acked, ignored
    sendStart(); sendByte(8'h00, a1); sendByte(8'h55, a2); sendStop();
    check(a2, "R5 other command acked", int'(a2), 1);

    // R6, R7: high-speed code, repeated start, wake, stop
    sendStart(); sendByte(8'h0B, a1);
    check(!a1, "R6 hs code not acked", int'(a1), 0);
    check(hsMode, "R6 hsMode set", int'(hsMode), 1);
    expQ.push_back(2);
    sendStart();
    check(hsMode, "R7 hsMode kept over repeated start", int'(hsMode), 1);
    sendByte(8'h00, a1); sendByte(8'h09, a2);
    check(hsMode, "R7 hsMode kept before stop", int'(hsMode), 1);
    sendStop();
    check(!hsMode, "R7 hsMode cleared by stop", int'(hsMode), 0);
    check(expQ.size() == 0, "R3 clear in hs mode", expQ.size(), 0);

    // R8: foreign address, data 0x06 ignored
    sendStart(); sendByte(8'hC0, a1); sendByte(8'h06, a2); sendStop();
    check(!a1, "R8 foreign address not acked", int'(a1), 0);
    check(!a2, "R8 following byte not acked", int'(a2), 0);
    check(!hsMode, "R8 no hs mode", int'(hsMode), 0);

    // R9: start in mid-byte
    expQ.push_back(1);
    sendStart();
    for (int i = 0; i < 4; i++) sendBit(1'b1);
    sendStart(); sendByte(8'h00, a1); sendByte(8'h06, a2); sendStop();
    check(a1, "R9 address after abort acked", int'(a1), 1);
    check(expQ.size() == 0, "R9 reload after abort", expQ.size(), 0);

    // R10: reset command clears hs mode without a stop
    expQ.push_back(1);
    sendStart(); sendByte(8'h08, a1);
    check(hsMode, "R10 hsMode set", int'(hsMode), 1);
    sendStart(); sendByte(8'h00, a1); sendByte(8'h06, a2);
    check(!hsMode, "R10 hsMode cleared by reset", int'(hsMode), 0);
    sendStop();
    check(expQ.size() == 0, "R10 reload seen", expQ.size(), 0);

    waitQ(2);
    check(sdaPullLow == 1'b0, "R11 idle pull-down", int'(sdaPullLow), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule